// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block runs one successive approximation conversion for each rising edge of a convert strobe. It drives a trial word toward an external capacitive DAC and reads back a one-bit comparator decision. Each bit is decided in turn, most significant first, and each decision takes a parameterised number of internal clock cycles. Analog sampling, the DAC, the comparator and the serial readout of the code are not part of the block.

The controller has two states. `ST_ACQ` is the powered-down acquisition state: the trial word is zero and `acq_o` is high. `ST_CONV` is the conversion state: `busy_o` is high and the trial word steps through the binary-weighted trials. The transition `start` (ST_ACQ to ST_CONV) fires on a rising edge of `convert_i` seen while in ST_ACQ. The transition `finish` (ST_CONV to ST_ACQ) fires when the least significant bit has been decided. On `finish` the final code goes out together with a one-cycle valid strobe, so there is no pipeline delay. The comparator convention is simple: `cmp_i` = 1 means the held sample is at or above the trial word. Because of this, an over-range input settles to all ones and an under-range input to all zeros, with no extra logic.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy_o = 0, valid_o = 0, result_o = 0, trial_o = 0 and acq_o = 1.
- R2: A rising edge of convert_i (low on one clock, high on the next) seen in ST_ACQ makes busy_o high on the following cycle, with trial_o = 1 << (DATA_W-1). A convert_i held high starts nothing more.
- R3: During a conversion with bit b under test, trial_o holds the already decided bits above b, has bit b set, and has all bits below b clear. Each bit stays under test for exactly CYC_PER_BIT cycles, starting at bit DATA_W-1 and going down to bit 0.
- R4: cmp_i is sampled on the last cycle of a bit's slot. A value of 1 keeps the bit under test and 0 clears it, so the final code equals the ideal code of the held sample.
- R5: busy_o stays high for exactly DATA_W*CYC_PER_BIT cycles per conversion.
- R6: valid_o is high for exactly one cycle, on the first cycle that busy_o is low after a conversion, and result_o carries the new code on that cycle.
- R7: result_o holds the last code until the next conversion completes.
- R8: A rising edge of convert_i while busy_o is high is ignored. The running conversion keeps its length and its code.
- R9: A sample at or above full scale (comparator always 1) gives 0xFFFF. A sample at or below zero (comparator always 0) gives 0x0000. Midscale gives 0x8000.
- R10: acq_o is high exactly when busy_o is low, and trial_o is 0 in acquisition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convert_i | input | 1 | Convert strobe; its rising edge starts a conversion |
| cmp_i | input | 1 | Comparator decision: 1 = sample at or above trial word |
| trial_o | output | DATA_W | Trial word toward the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | DATA_W | Last completed code, straight binary |
| valid_o | output | 1 | One-cycle strobe marking a new result_o |
| acq_o | output | 1 | Acquisition / power-down indicator |

## Verification
The bench builds the block with DATA_W = 16 and CYC_PER_BIT = 3. With an odd, non-power-of-two slot length, the pacing counter has to wrap early instead of overflowing naturally, and each bit slot lasts 3 cycles, so a trial word that is off by one cycle shows up at once. The 48-cycle conversion is short enough to run full-scale, zero, midscale, neighbouring codes, out-of-range samples, retriggers and back-to-back starts, each checked cycle by cycle against a behavioural model.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic {
        ST_ACQ  = 1'b0,
        ST_CONV = 1'b1
    } sar_state_e;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/sar_pacer.sv
module sar_pacer import sar_pkg::*; #(
    parameter int CYC_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = cnt_width(CYC_PER_BIT);

    generate
        if (CYC_PER_BIT == 1) begin : g_direct
            assign tick_o = run_i;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            logic          wrap;

            assign wrap   = (cnt_q == CW'(CYC_PER_BIT - 1));
            assign tick_o = run_i & wrap;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      cnt_q <= '0;
                else if (!run_i) cnt_q <= '0;
                else if (wrap)   cnt_q <= '0;
                else             cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] trial_o,
    output logic [DATA_W-1:0] decided_o,
    output logic              last_o
);
    localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] probe_q;
    logic [DATA_W-1:0] trial_q;

    assign decided_o = cmp_i ? trial_q : (trial_q & ~probe_q);
    assign last_o    = probe_q[0];
    assign trial_o   = trial_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            probe_q <= '0;
            trial_q <= '0;
        end else if (load_i) begin
            probe_q <= TOP_BIT;
            trial_q <= TOP_BIT;
        end else if (step_i) begin
            probe_q <= probe_q >> 1;
            trial_q <= decided_o | (probe_q >> 1);
        end
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl import sar_pkg::*; #(
    parameter int DATA_W      = 16,
    parameter int CYC_PER_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              convert_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] trial_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              acq_o
);
    sar_state_e        state_q, state_d;
    logic              rise, start, tick, last, done;
    logic [DATA_W-1:0] trial_w, decided_w;
    logic [DATA_W-1:0] result_q;
    logic              valid_q;

    sar_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (convert_i),
        .rise_o  (rise)
    );

    sar_pacer #(.CYC_PER_BIT(CYC_PER_BIT)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_CONV),
        .tick_o (tick)
    );

    sar_reg #(.DATA_W(DATA_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start),
        .step_i    (tick),
        .cmp_i     (cmp_i),
        .trial_o   (trial_w),
        .decided_o (decided_w),
        .last_o    (last)
    );

    assign start = (state_q == ST_ACQ) & rise;
    assign done  = tick & last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQ:  if (start) state_d = ST_CONV;
            ST_CONV: if (done)  state_d = ST_ACQ;
            default: state_d = ST_ACQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQ;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= done;
            if (done) result_q <= decided_w;
        end
    end

    assign busy_o   = (state_q == ST_CONV);
    assign acq_o    = (state_q == ST_ACQ);
    assign trial_o  = busy_o ? trial_w : '0;
    assign result_o = result_q;
    assign valid_o  = valid_q;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              convert_i,
    input logic [DATA_W-1:0] trial_o,
    input logic              busy_o,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o
);
    a_r2_start_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $rose(convert_i)) |=> (busy_o && trial_o == {1'b1, {(DATA_W-1){1'b0}}}));

    a_r3_trial_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (trial_o != '0));

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r6_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!busy_o && $past(busy_o)));

    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));

    a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || valid_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .convert_i (convert_i),
    .trial_o   (trial_o),
    .busy_o    (busy_o),
    .result_o  (result_o),
    .valid_o   (valid_o)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;
    localparam int W = 16;
    localparam int C = 3;
    localparam int CONV_CYC = W * C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         convert = 1'b0;
    logic         cmp;
    logic [W-1:0] trial, result;
    logic         busy, valid, acq;

    int vin = 0;
    int held = 0;
    int errors = 0;
    int checks = 0;
    int wd = 0;

    // reference model state
    int           m_busy = 0;
    int           m_cyc = 0;
    bit           m_prev = 0;
    bit           m_valid = 0;
    logic [W-1:0] m_result = '0;

    always #2.5 clk = ~clk;

    // behavioural DAC + comparator on the held sample
    assign cmp = (held >= int'(trial));

    sar_conv_ctrl #(.DATA_W(W), .CYC_PER_BIT(C)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .convert_i (convert),
        .cmp_i     (cmp),
        .trial_o   (trial),
        .busy_o    (busy),
        .result_o  (result),
        .valid_o   (valid),
        .acq_o     (acq)
    );

    function automatic int ideal(input int v);
        if (v < 0) return 0;
        if (v > 65535) return 65535;
        return v;
    endfunction

    function automatic int exp_trial();
        int code, b, hi;
        if (m_busy == 0) return 0;
        code = ideal(held);
        b    = (W - 1) - (m_cyc / C);
        hi   = (code >> (b + 1)) << (b + 1);
        return hi | (1 << b);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit rise;
        if (!rst_n) begin
            m_busy = 0; m_cyc = 0; m_prev = 0; m_valid = 0; m_result = '0;
        end else begin
            rise    = convert && !m_prev;
            m_prev  = convert;
            m_valid = 0;
            if (m_busy == 0) begin
                if (rise) begin
                    held   = vin;
                    m_busy = 1;
                    m_cyc  = 0;
                end
            end else begin
                m_cyc++;
                if (m_cyc == CONV_CYC) begin
                    m_result = W'(ideal(held));
                    m_valid  = 1;
                    m_busy   = 0;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy[0], "R5", busy, m_busy);
            check(valid == m_valid, "R6", valid, m_valid);
            check(result == m_result, "R7", result, m_result);
            check(acq == !busy, "R10", acq, !busy);
            check(int'(trial) == exp_trial(), "R3", trial, exp_trial());
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL R5 watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // start a conversion, hold convert high, count busy cycles
    task automatic run_conv(input int v, input int exp_code, input string tag, input bit retrig);
        int n = 0;
        @(negedge clk);
        vin = v;
        convert = 1'b1;
        @(negedge clk);
        while (busy) begin
            n++;
            if (retrig && n == 10) convert = 1'b0;
            if (retrig && n == 12) begin convert = 1'b1; vin = 12345; end
            @(negedge clk);
        end
        check(n == CONV_CYC, retrig ? "R8" : "R5", n, CONV_CYC);
        check(valid == 1'b1, "R6", valid, 1);
        check(int'(result) == exp_code, tag, result, exp_code);
        convert = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && valid == 0 && result == 0 && trial == 0 && acq == 1,
              "R1", {busy, valid, acq}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);

        run_conv(32768, 16'h8000, "R9", 0);
        run_conv(65535, 16'hFFFF, "R9", 0);
        run_conv(0,     16'h0000, "R9", 0);
        run_conv(70000, 16'hFFFF, "R9", 0);
        run_conv(-500,  16'h0000, "R9", 0);
        run_conv(16'h5A5A, 16'h5A5A, "R4", 0);
        run_conv(32767, 16'h7FFF, "R4", 0);
        run_conv(1,     16'h0001, "R4", 0);
        run_conv(16'hA5C3, 16'hA5C3, "R8", 1);

        // R2: convert held high across completion starts nothing new
        @(negedge clk);
        vin = 999;
        convert = 1'b1;
        repeat (CONV_CYC + 6) @(negedge clk);
        check(busy == 0, "R2", busy, 0);
        check(result == 16'd999, "R7", result, 999);
        convert = 1'b0;

        // R2: back-to-back, new edge on the cycle valid rises
        @(negedge clk);
        vin = 4660;
        convert = 1'b1;
        @(negedge clk);
        convert = 1'b0;
        while (!valid) @(negedge clk);
        vin = 22136;
        convert = 1'b1;
        @(negedge clk);
        check(busy == 1 && trial == 16'h8000, "R2", trial, 16'h8000);
        convert = 1'b0;
        while (!valid) @(negedge clk);
        check(result == 16'd22136, "R4", result, 22136);

        for (int i = 0; i < 6; i++) begin
            int v = (i * 9973 + 311) % 65536;
            run_conv(v, v, "R4", 0);
        end

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule